// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial output line. Software places a byte into a one-entry holding buffer. On the next baud enable the byte moves into a separate shift stage, which sends a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Because the shift stage and the buffer are separate, software can load the next byte while the current frame is still going out. A byte that is waiting goes out straight after the current stop bit, with no idle time between the two frames.

Software reads two flags. One says the buffer is empty; the other says the shift stage has finished its frame. One mode input decides when the transmit interrupt request is raised: either when a byte leaves the buffer for the shift stage, or only when a whole frame, stop bit included, has been sent. The request stays latched until a clear strobe removes it. Bit timing comes from an external single-cycle baud enable, and every bit lasts a fixed number of these enables.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, txd is 1, status bit 0 (buffer empty) is 1, status bit 2 (shift complete) is 1, status bit 1 is 0 and irq_req is 0.
- R2: The cycle after wr_en is sampled high, status bit 0 reads 0 and the written byte is held for transmission.
- R3: If the shift stage is idle and the buffer is full, the byte moves to the shift stage on the next baud_tick. Status bit 0 returns to 1 in the following cycle, unless wr_en is high in that same cycle.
- R4: A frame on txd is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts 16 baud_tick pulses, counted from the tick that loaded the frame.
- R5: Status bit 2 reads 0 from the cycle after a load until the stop bit's final baud_tick. After that tick it reads 1 again, unless another frame loads on that same tick.
- R6: If the buffer is full when the stop bit's final baud_tick arrives, the next frame's start bit begins in the next cycle, with no idle bit.
- R7: A write while the buffer is already full replaces the waiting byte and leaves both status flags unchanged. The later byte is the one sent.
- R8: With irq_mode = 0, irq_req is set in the cycle after each transfer from the buffer into the shift stage.
- R9: With irq_mode = 1, irq_req is set only in the cycle after a frame's final stop-bit tick. Transfers into the shift stage do not set it.
- R10: irq_req stays set until irq_clr is pulsed. If a set event and irq_clr occur in the same cycle, irq_req stays 1.
- R11: Whenever status bit 2 reads 1, txd is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle baud enable; 16 of these make one bit |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| irq_mode | input | 1 | 0: request on buffer transfer, 1: request on frame end |
| irq_clr | input | 1 | Single-cycle clear of the interrupt request |
| txd | output | 1 | Serial output line, idles at 1 |
| status | output | 3 | Bit 0 buffer empty, bit 1 always 0, bit 2 shift complete |
| irq_req | output | 1 | Latched transmit interrupt request |

## Verification
The assertions assume that every input is a known value sampled at the rising edge, and that baud_tick is a single-cycle strobe that is never high in two consecutive cycles. They also assume that irq_mode is only compared with the event of the cycle in which it is sampled. The bench changes all inputs at the falling edge. Its random phase only raises baud_tick when it was low in the cycle before. It toggles irq_mode at random times, including during frames, so both interrupt sources run against a reference model built from tick counts.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    IRQ_ON_EMPTY = 1'b0,
    IRQ_ON_DONE  = 1'b1
  } irq_mode_e;

  localparam int STS_W         = 3;
  localparam int STS_EMPTY_BIT = 0;
  localparam int STS_DONE_BIT  = 2;
endpackage

// File: rtl/uart_hold_buf.sv
module uart_hold_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          hold_full
);
  // A write always wins over a take in the same cycle: the shift stage
  // captures the old byte and the new byte stays pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_frame_shifter.sv
module uart_frame_shifter #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          start_req,
  input  logic [DW-1:0] load_data,
  output logic          load,
  output logic          frame_done,
  output logic          busy,
  output logic          txd
);
  localparam int NBITS = DW + 2;
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic [DW-1:0]    shreg;
  logic             bit_end;
  logic             last_slot;

  // Line level for a frame position: 0 start, data LSB first, then stop.
  function automatic logic frame_level(input logic [IDX_W-1:0] idx,
                                       input logic [DW-1:0] data);
    logic [DW-1:0] sh;
    if (idx == '0) return 1'b0;
    if (idx > IDX_W'(DW)) return 1'b1;
    sh = data >> (idx - IDX_W'(1));
    return sh[0];
  endfunction

  assign bit_end    = busy && (tick_cnt == CNT_LAST);
  assign last_slot  = bit_end && (bit_idx == IDX_LAST);
  assign load       = baud_tick && start_req && (!busy || last_slot);
  assign frame_done = baud_tick && last_slot;
  assign txd        = busy ? frame_level(bit_idx, shreg) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= load_data;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tick_cnt <= '0;
        if (last_slot) begin
          busy    <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + IDX_W'(1);
        end
      end else begin
        tick_cnt <= tick_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req <= 1'b0;
    else if (set_evt) req <= 1'b1;
    else if (clr)     req <= 1'b0;
  end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             irq_mode,
  input  logic             irq_clr,
  output logic             txd,
  output logic [STS_W-1:0] status,
  output logic             irq_req
);
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          xfer_load;
  logic          frame_done;
  logic          shift_busy;
  logic          irq_evt;
  irq_mode_e     mode_sel;

  uart_hold_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(xfer_load), .hold_data(hold_data), .hold_full(hold_full)
  );

  uart_frame_shifter #(.DW(DW), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .start_req(hold_full), .load_data(hold_data),
    .load(xfer_load), .frame_done(frame_done),
    .busy(shift_busy), .txd(txd)
  );

  assign mode_sel = irq_mode_e'(irq_mode);
  assign irq_evt  = (mode_sel == IRQ_ON_DONE) ? frame_done : xfer_load;

  uart_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(irq_evt), .clr(irq_clr), .req(irq_req)
  );

  always_comb begin
    status                = '0;
    status[STS_EMPTY_BIT] = ~hold_full;
    status[STS_DONE_BIT]  = ~shift_busy;
  end
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic       wr_en,
  input logic       irq_mode,
  input logic       irq_clr,
  input logic       txd,
  input logic [2:0] status,
  input logic       irq_req,
  input logic       xfer_load,
  input logic       frame_done,
  input logic       irq_evt
);
  // R2
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !status[0]);
  // R3
  load_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |-> (baud_tick && !status[0]));
  // R3
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_load && !wr_en) |=> status[0]);
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |=> !txd);
  // R5
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |=> !status[2]);
  // R5
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !xfer_load) |=> status[2]);
  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> txd);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> irq_req);
  // R9
  irq_done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && !frame_done && !irq_req) |=> !irq_req);
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_evt) |=> !irq_req);
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .irq_mode(irq_mode), .irq_clr(irq_clr), .txd(txd), .status(status),
  .irq_req(irq_req), .xfer_load(xfer_load), .frame_done(frame_done),
  .irq_evt(irq_evt)
);

// File: tb/uart_dbuf_tx_tb.sv
module uart_dbuf_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq_mode = 1'b0;
  logic       irq_clr = 1'b0;
  logic       txd;
  logic [2:0] status;
  logic       irq_req;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  uart_dbuf_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .irq_mode(irq_mode), .irq_clr(irq_clr),
    .txd(txd), .status(status), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: position in frame as a tick count 0..159.
  logic       m_full, m_busy, m_irq;
  logic [7:0] m_hold, m_data;
  int         m_cnt;

  function automatic logic exp_line(input logic busy, input int cnt, input logic [7:0] d);
    int slot;
    if (!busy) return 1'b1;
    slot = cnt / 16;
    if (slot == 0) return 1'b0;
    if (slot >= 9) return 1'b1;
    return d[slot-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full <= 1'b0; m_busy <= 1'b0; m_irq <= 1'b0;
      m_hold <= '0; m_data <= '0; m_cnt <= 0;
    end else begin
      logic at_end, ld, fin, evt;
      at_end = m_busy && (m_cnt == 159);
      ld  = baud_tick && m_full && (!m_busy || at_end);
      fin = baud_tick && at_end;
      if (ld) begin
        m_busy <= 1'b1; m_cnt <= 0; m_data <= m_hold;
      end else if (m_busy && baud_tick) begin
        if (at_end) m_busy <= 1'b0;
        else m_cnt <= m_cnt + 1;
      end
      if (wr_en) begin m_full <= 1'b1; m_hold <= wr_data; end
      else if (ld) m_full <= 1'b0;
      evt = irq_mode ? fin : ld;
      if (evt) m_irq <= 1'b1;
      else if (irq_clr) m_irq <= 1'b0;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R4 txd vs model", 32'(txd), 32'(exp_line(m_busy, m_cnt, m_data)));
      check("R2 buffer empty vs model", 32'(status[0]), 32'(!m_full));
      check("R5 shift complete vs model", 32'(status[2]), 32'(!m_busy));
      check("R10 irq_req vs model", 32'(irq_req), 32'(m_irq));
    end
  end

  // Line monitor: samples the middle of each bit to rebuild sent bytes
  logic [7:0] rx_sh = '0;
  logic [7:0] last_rx = '0;
  always @(negedge clk) begin
    if (rst_n && m_busy && (m_cnt % 16 == 8)) begin
      int slot;
      slot = m_cnt / 16;
      if (slot >= 1 && slot <= 8) rx_sh[slot-1] = txd;
      else if (slot == 9) last_rx = rx_sh;
    end
  end

  task automatic pulse_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired before the run ended");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 idle line
    check("R1 txd after reset", 32'(txd), 32'd1);
    check("R1 status after reset", 32'(status), 32'b101);
    check("R1 irq after reset", 32'(irq_req), 32'd0);

    // R2 write marks buffer full, nothing sent yet
    pulse_wr(8'h3C);
    check("R2 buffer empty after write", 32'(status[0]), 32'd0);
    check("R11 line idle before tick", 32'(txd), 32'd1);

    // R3 transfer on tick; R4 start bit; R5 busy; R8 irq in mode 0
    tick_n(1);
    check("R3 buffer empty after transfer", 32'(status[0]), 32'd1);
    check("R4 start bit low", 32'(txd), 32'd0);
    check("R5 shift complete low in frame", 32'(status[2]), 32'd0);
    check("R8 irq on transfer", 32'(irq_req), 32'd1);

    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R10 irq cleared", 32'(irq_req), 32'd0);

    // R7 overwrite while full
    pulse_wr(8'h11);
    check("R7 full after first write", 32'(status), 32'b000);
    pulse_wr(8'h22);
    check("R7 flags unchanged on overwrite", 32'(status), 32'b000);

    tick_n(159);
    check("R4 stop bit high", 32'(txd), 32'd1);
    check("R4 first byte on line", 32'(last_rx), 32'h3C);
    // R6 back-to-back start
    tick_n(1);
    check("R6 next start bit without gap", 32'(txd), 32'd0);
    check("R6 still shifting", 32'(status[2]), 32'd0);
    check("R6 buffer drained", 32'(status[0]), 32'd1);

    // R9 mode 1: irq only at frame end
    irq_mode = 1'b1; irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    tick_n(159);
    check("R9 no irq before frame end", 32'(irq_req), 32'd0);
    tick_n(1);
    check("R9 irq at frame end", 32'(irq_req), 32'd1);
    check("R5 shift complete after stop", 32'(status[2]), 32'd1);
    check("R11 line idle after frame", 32'(txd), 32'd1);
    check("R7 overwritten byte sent", 32'(last_rx), 32'h22);

    // R10 event and clear in the same cycle: event wins
    irq_mode = 1'b0;
    pulse_wr(8'h5A);
    baud_tick = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0; irq_clr = 1'b0;
    check("R10 set beats clear", 32'(irq_req), 32'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R10 clear alone", 32'(irq_req), 32'd0);
    tick_n(160);
    check("R4 third byte on line", 32'(last_rx), 32'h5A);

    // Random phase, checked every cycle against the model
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      baud_tick = !baud_tick && ($urandom % 3 == 0);
      wr_en     = ($urandom % 350 == 0);
      wr_data   = 8'($urandom);
      irq_clr   = ($urandom % 90 == 0);
      if ($urandom % 1200 == 0) irq_mode = ~irq_mode;
    end
    baud_tick = 1'b0; wr_en = 1'b0; irq_clr = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule